// File: doc/BRIEF.md
# Pixel Color Component Extractor

This block sits between a frame-buffer fetch path and a display output. Each clock it may take one raw pixel word and turn it into three 8-bit colour channels: red, green and blue. Software sets the pixel layout through a small write port. One register gives how many bytes wide a pixel is. Three channel registers each give where that channel's bits sit in the word, how many bits it has, and a fallback colour.

A channel shows its fallback colour in three cases: its field length is zero, the pixel is flagged as lying outside the visible area, or the upstream line buffer reports an underrun. If the red fallback is set to full scale, underruns show up as red on the screen. Fields narrower than eight bits are scaled up by repeating their bits, so a field of all ones becomes 0xFF. The result is registered once, and a valid strobe travels with it.

Top module: `pix_chan_extract`

## Requirements
- R1: After reset, `outValid` is low and all three channels read 0x00. Reset leaves every channel length at zero, every fallback at 0x00 and the pixel width at one byte.
- R2: Each channel register holds the lowest bit index of the field in bits [4:0] and the field length in bits [11:8]. The channel output is built from bits offset .. offset+length-1 of the pixel word.
- R3: A channel whose length field is zero outputs its fallback value, held in bits [23:16] of its register.
- R4: When `inArea` is low, every channel outputs its own fallback value.
- R5: When `underrun` is high, every channel outputs its own fallback value. This takes priority over the pixel data, so a red fallback of 0xFF paints underruns red.
- R6: Bits [4:3] of the format register hold the bytes per pixel minus one (0 means one byte). Pixel bits at or above bytes*8 read as zero, including field bits that run past that width.
- R7: A field of length L<8 is placed at the top of the 8-bit output, and its bits are repeated downward to fill the low bits (all ones gives 0xFF). A field of L>=8 outputs its top 8 bits.
- R8: Channel outputs and `outValid` appear one clock after the inputs are sampled, and `outValid` equals the `pixValid` of that cycle.
- R9: Writes go to address 0 (format), 1 (red), 2 (green) and 3 (blue), and take effect from the next clock. A pixel in the same cycle as a write uses the old settings. Writes to any other address change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | ADDR_W | Register write address |
| wrData | input | 32 | Register write data |
| pixValid | input | 1 | Pixel word present this cycle |
| pixWord | input | PIX_W | Raw pixel word, byte 0 in the low bits |
| inArea | input | 1 | Pixel lies inside the visible area |
| underrun | input | 1 | Line buffer has no data for this pixel |
| outValid | output | 1 | Channel outputs carry a pixel |
| red | output | 8 | Red channel |
| green | output | 8 | Green channel |
| blue | output | 8 | Blue channel |

## Verification
The bench builds the block with its default 32-bit pixel word and a 4-bit address. This makes all four pixel widths from one to four bytes reachable. It also lets field offsets up to 31 push a field past the pixel width, into the zero-fill region. With 16 decodable addresses, writes to the unused addresses 4 to 15 can be shown to change nothing. Field lengths from 1 up to 15 are covered, which exercises both the bit-repeat path and the truncation path.

// File: rtl/pce_pkg.sv
package pce_pkg;
  localparam int CH_W    = 8;   // channel output width
  localparam int OFF_W   = 5;   // field offset width, bits [4:0]
  localparam int LEN_W   = 4;   // field length width, bits [11:8]
  localparam int LEN_LSB = 8;
  localparam int DFL_LSB = 16;  // fallback colour, bits [23:16]
  localparam int BPP_W   = 2;   // bytes-per-pixel minus one
  localparam int BPP_LSB = 3;
  localparam int N_CH    = 3;

  typedef struct packed {
    logic [CH_W-1:0]  dflt;
    logic [LEN_W-1:0] len;
    logic [OFF_W-1:0] off;
  } chanSel_t;

  typedef struct packed {
    chanSel_t [N_CH-1:0] sel;   // index 0 red, 1 green, 2 blue
    logic [BPP_W-1:0]    bppM1;
  } cfgStrobe_t;
endpackage

// File: rtl/pce_ctrl.sv
module pce_ctrl
  import pce_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [31:0]       wrData,
  output cfgStrobe_t        cfg
);
  localparam logic [ADDR_W-1:0] ADDR_FMT = ADDR_W'(0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= '0;
    end else if (wrEn) begin
      if (wrAddr == ADDR_FMT) begin
        cfg.bppM1 <= wrData[BPP_LSB +: BPP_W];
      end
      for (int c = 0; c < N_CH; c++) begin
        if (wrAddr == ADDR_W'(c + 1)) begin
          cfg.sel[c].off  <= wrData[OFF_W-1:0];
          cfg.sel[c].len  <= wrData[LEN_LSB +: LEN_W];
          cfg.sel[c].dflt <= wrData[DFL_LSB +: CH_W];
        end
      end
    end
  end
endmodule

// File: rtl/pce_datapath.sv
module pce_datapath
  import pce_pkg::*;
#(
  parameter int PIX_W = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  cfgStrobe_t                 cfg,
  input  logic                       pixValid,
  input  logic [PIX_W-1:0]           pixWord,
  input  logic                       inArea,
  input  logic                       underrun,
  output logic                       outValid,
  output logic [N_CH-1:0][CH_W-1:0]  chOut
);
  localparam int N_BYTES = PIX_W / 8;
  localparam int FLD_W   = 1 << LEN_W;

  logic [PIX_W-1:0] byteMask;
  logic [PIX_W-1:0] masked;
  logic             forceDflt;

  always_comb begin
    for (int k = 0; k < N_BYTES; k++) begin
      byteMask[k*8 +: 8] = (k <= int'(cfg.bppM1)) ? 8'hFF : 8'h00;
    end
  end

  assign masked    = pixWord & byteMask;
  assign forceDflt = !inArea || underrun;

  for (genvar c = 0; c < N_CH; c++) begin : g_chan
    logic [PIX_W+FLD_W-1:0] ext;
    logic [FLD_W-1:0]       lenMask;
    logic [FLD_W-1:0]       field;
    logic [CH_W-1:0]        expd;

    assign ext     = {{FLD_W{1'b0}}, masked} >> cfg.sel[c].off;
    assign lenMask = (FLD_W'(1) << cfg.sel[c].len) - FLD_W'(1);
    assign field   = ext[FLD_W-1:0] & lenMask;

    always_comb begin
      int lenI;
      int idx;
      lenI = int'(cfg.sel[c].len);
      for (int i = 0; i < CH_W; i++) begin
        if (lenI >= CH_W)   idx = lenI - CH_W + i;
        else if (lenI != 0) idx = lenI - 1 - ((CH_W - 1 - i) % lenI);
        else                idx = 0;
        expd[i] = field[idx[LEN_W-1:0]];
      end
    end

    always_ff @(posedge clk) begin
      if (rst) chOut[c] <= '0;
      else if (forceDflt || cfg.sel[c].len == '0) chOut[c] <= cfg.sel[c].dflt;
      else chOut[c] <= expd;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) outValid <= 1'b0;
    else     outValid <= pixValid;
  end
endmodule

// File: rtl/pix_chan_extract.sv
module pix_chan_extract
  import pce_pkg::*;
#(
  parameter int PIX_W  = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [31:0]       wrData,
  input  logic              pixValid,
  input  logic [PIX_W-1:0]  pixWord,
  input  logic              inArea,
  input  logic              underrun,
  output logic              outValid,
  output logic [7:0]        red,
  output logic [7:0]        green,
  output logic [7:0]        blue
);
  cfgStrobe_t                cfg;
  logic [N_CH-1:0][CH_W-1:0] chOut;

  pce_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .cfg(cfg)
  );

  pce_datapath #(.PIX_W(PIX_W)) u_dp (
    .clk(clk), .rst(rst), .cfg(cfg), .pixValid(pixValid), .pixWord(pixWord),
    .inArea(inArea), .underrun(underrun), .outValid(outValid), .chOut(chOut)
  );

  assign red   = chOut[0];
  assign green = chOut[1];
  assign blue  = chOut[2];
endmodule

// File: rtl/pce_checker.sv
module pce_checker
  import pce_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic              pixValid,
  input logic              inArea,
  input logic              underrun,
  input logic              outValid,
  input logic [7:0]        red,
  input logic [7:0]        green,
  input logic [7:0]        blue,
  input cfgStrobe_t        cfg
);
  AST_VALID_LAG: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> outValid == $past(pixValid)); // R8

  AST_ZERO_LEN_DFLT: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cfg.sel[2].len) == '0) |-> blue == $past(cfg.sel[2].dflt)); // R3

  AST_OUTSIDE_DFLT: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(inArea)) |-> red == $past(cfg.sel[0].dflt)); // R4

  AST_UNDERRUN_DFLT: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(underrun)) |-> green == $past(cfg.sel[1].dflt)); // R5

  AST_IGNORE_ADDR: assert property (@(posedge clk) disable iff (rst)
    (wrEn && wrAddr > ADDR_W'(3)) |=> $stable(cfg)); // R9
endmodule

bind pix_chan_extract pce_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .pixValid(pixValid),
  .inArea(inArea), .underrun(underrun), .outValid(outValid),
  .red(red), .green(green), .blue(blue), .cfg(cfg)
);

// File: tb/pix_chan_extract_tb.sv
module pix_chan_extract_tb;
  localparam int PIX_W  = 32;
  localparam int ADDR_W = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wrEn = 1'b0;
  logic [ADDR_W-1:0] wrAddr = '0;
  logic [31:0] wrData = '0;
  logic pixValid = 1'b0;
  logic [PIX_W-1:0] pixWord = '0;
  logic inArea = 1'b1;
  logic underrun = 1'b0;
  logic outValid;
  logic [7:0] red, green, blue;

  int total = 0;
  int fails = 0;
  bit done = 0;

  // bench-side register shadow and one-deep expectation queue
  logic [31:0] shSel [3];
  logic [31:0] shFmt;
  logic [7:0]  expCh [$];
  bit          expV [$];
  string       expTag [$];

  always #10 clk = ~clk;

  pix_chan_extract #(.PIX_W(PIX_W), .ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .pixValid(pixValid), .pixWord(pixWord), .inArea(inArea), .underrun(underrun),
    .outValid(outValid), .red(red), .green(green), .blue(blue)
  );

  function automatic logic [7:0] refChan(logic [31:0] sel, logic [31:0] fmt,
                                        logic [31:0] word, bit area, bit und);
    int off, len, nbits, bits;
    longint field, acc;
    off = int'(sel[4:0]);
    len = int'(sel[11:8]);
    nbits = (int'(fmt[4:3]) + 1) * 8;
    if (!area || und || len == 0) return sel[23:16];
    field = 0;
    for (int i = 0; i < len; i++) begin
      if (off + i < nbits) field = field | (((longint'(word) >> (off + i)) & 1) << i);
    end
    if (len >= 8) return 8'(field >> (len - 8));
    acc = 0;
    bits = 0;
    while (bits < 8) begin
      acc = (acc << len) | field;
      bits += len;
    end
    return 8'(acc >> (bits - 8));
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // compare the previous cycle's result, then apply one cycle of stimulus
  task automatic step(bit we, int addr, logic [31:0] data, bit v,
                      logic [31:0] word, bit area, bit und, string tag);
    string t;
    @(negedge clk);
    if (expV.size() != 0) begin
      chk("R8", "outValid", int'(outValid), int'(expV[0]));
      if (expV[0]) begin
        chk(expTag[0], "red",   int'(red),   int'(expCh[0]));
        chk(expTag[0], "green", int'(green), int'(expCh[1]));
        chk(expTag[0], "blue",  int'(blue),  int'(expCh[2]));
      end
      expV.delete(); expCh.delete(); expTag.delete();
    end
    wrEn = we; wrAddr = ADDR_W'(addr); wrData = data;
    pixValid = v; pixWord = word; inArea = area; underrun = und;
    t = tag;
    if (t == "") begin
      if (und)        t = "R5";
      else if (!area) t = "R4";
      else            t = "R2";
    end
    expV.push_back(v);
    expTag.push_back(t);
    for (int c = 0; c < 3; c++) expCh.push_back(refChan(shSel[c], shFmt, word, area, und));
    if (we) begin
      if (addr == 0) shFmt = data;
      else if (addr >= 1 && addr <= 3) shSel[addr-1] = data;
    end
  endtask

  task automatic wr(int addr, logic [31:0] data);
    step(1, addr, data, 0, 32'h0, 1, 0, "R9");
  endtask

  task automatic px(logic [31:0] word, string tag = "");
    step(0, 0, 32'h0, 1, word, 1, 0, tag);
  endtask

  function automatic logic [31:0] mkSel(int dflt, int len, int off);
    return (32'(dflt) << 16) | (32'(len) << 8) | 32'(off);
  endfunction

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1;
      total++; fails++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    shFmt = '0;
    for (int c = 0; c < 3; c++) shSel[c] = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1", "outValid", int'(outValid), 0);
    chk("R1", "red", int'(red), 0);
    chk("R1", "green", int'(green), 0);
    chk("R1", "blue", int'(blue), 0);
    // R1: reset config is len 0, fallback 0
    px(32'hDEADBEEF, "R1");

    // 32-bit xRGB, 8-bit fields
    wr(0, 32'h3 << 3);
    wr(1, mkSel(8'hFF, 8, 16));
    wr(2, mkSel(8'h10, 8, 8));
    // R9: pixel in the same cycle as a write still uses old blue settings
    step(1, 3, mkSel(8'h20, 8, 0), 1, 32'h00123456, 1, 0, "R9");
    px(32'h00123456);
    px(32'h00FF00AA);
    px(32'h00000000);
    px(32'hFFABCDEF);
    // R8: gaps in valid
    step(0, 0, 0, 0, 32'h00112233, 1, 0, "R8");
    px(32'h00445566, "R8");
    step(0, 0, 0, 0, 32'h0, 1, 0, "R8");
    // R4 / R5
    step(0, 0, 0, 1, 32'h00123456, 0, 0, "R4");
    step(0, 0, 0, 1, 32'h00123456, 1, 1, "R5");
    step(0, 0, 0, 1, 32'h00123456, 0, 1, "R5");
    // R3: zero length on blue
    wr(3, mkSel(8'h5A, 0, 0));
    px(32'h00778899, "R3");

    // R7: 16-bit 5/6/5 layout, replicated fill
    wr(0, 32'h1 << 3);
    wr(1, mkSel(8'h00, 5, 11));
    wr(2, mkSel(8'h00, 6, 5));
    wr(3, mkSel(8'h00, 5, 0));
    px(32'h0000FFFF, "R7");
    px(32'h00008410, "R7");
    px(32'h00000001, "R7");
    px(32'hFFFF7BEF, "R6");
    // R7: odd lengths and length above 8
    wr(0, 32'h3 << 3);
    wr(1, mkSel(0, 3, 0));
    wr(2, mkSel(0, 1, 4));
    wr(3, mkSel(0, 12, 2));
    px(32'h00000015, "R7");
    px(32'h00003FFC, "R7");
    px(32'h00002A58, "R7");

    // R6: one-byte pixels, upper bytes read as zero
    wr(0, 32'h0);
    wr(1, mkSel(0, 8, 8));
    wr(2, mkSel(0, 8, 4));
    wr(3, mkSel(0, 8, 0));
    px(32'hFFFFFFA5, "R6");
    wr(0, 32'h2 << 3);
    px(32'hFFFFFFA5, "R6");
    wr(1, mkSel(0, 8, 20));
    px(32'hFFFFFFFF, "R6");

    // R9: writes to unused addresses change nothing
    for (int a = 4; a < 16; a++) wr(a, 32'h00FF0000);
    px(32'h00C3A5F0, "R9");

    // R5: underrun shown as red
    wr(1, mkSel(8'hFF, 8, 16));
    wr(2, mkSel(8'h00, 8, 8));
    wr(3, mkSel(8'h00, 8, 0));
    step(0, 0, 0, 1, 32'h00123456, 1, 1, "R5");

    // mixed traffic
    for (int n = 0; n < 400; n++) begin
      int r;
      r = int'($urandom_range(0, 9));
      if (r == 0)
        wr(int'($urandom_range(0, 7)), $urandom());
      else
        step(0, 0, 0, bit'($urandom_range(0, 7) != 0), $urandom(),
             bit'($urandom_range(0, 5) != 0), bit'($urandom_range(0, 7) == 0), "");
    end
    step(0, 0, 0, 0, 32'h0, 1, 0, "R8");
    step(0, 0, 0, 0, 32'h0, 1, 0, "R8");

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule